// File: doc/BRIEF.md
# ADC Result Formatter with Read-Order Lock

This block sits between an analog-to-digital converter core and a register-read bus. When the converter signals that a conversion is complete, the block captures the 10-bit result. Software reads it back through two 8-bit registers, the upper and the lower. A 2-bit format select chooses how the result is laid out across those two registers. The formats are left aligned, right aligned, left aligned with the top bit inverted (an offset-from-mid-scale signed reading), and an 8-bit truncated form.

In the three 10-bit formats, a read-order lock guards the held result. Once a result is captured, further conversions are discarded until software has read the upper register and then the lower one. In the truncated format the lock is bypassed, so every conversion is stored. Formatting is applied on read, so a change of format re-presents the result already held.

Top module: `adc_result_port`

## Requirements
- R1: After reset, both registers read 0x00 and the lock is released, so the first conversion is captured.
- R2: Format 2'b00 (left aligned): the upper register holds result bits 9:2, and the lower register holds result bits 1:0 in its bits 7:6 with zeros below.
- R3: Format 2'b01 (right aligned): the upper register holds result bits 9:8 in its bits 1:0 with zeros above, and the lower register holds result bits 7:0.
- R4: Format 2'b10 (signed left aligned): the layout is as in R2, except that bit 7 of the upper register is the inverse of result bit 9.
- R5: Format 2'b11 (truncated): the lower register holds result bits 9:2 and the upper register reads 0x00.
- R6: Outside format 2'b11, storing a conversion engages the lock. A conversion that completes while the lock is engaged is dropped, and the held value is unchanged.
- R7: A read strobe with rd_sel=1 (upper register), followed later by a read strobe with rd_sel=0 (lower register), releases the lock. The next completed conversion is then captured.
- R8: A lower-register read that occurs before any upper-register read does not release the lock.
- R9: In format 2'b11, every completed conversion is stored. Neither stores nor reads change the lock state, and the lock state is kept for when the format returns to a 10-bit mode.
- R10: Changing the format select reformats the held result at once and does not change the lock state.
- R11: A conversion that completes in the same cycle as the releasing lower-register read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_done | input | 1 | One-cycle strobe: conversion complete |
| conv_data | input | 10 | Conversion result, valid with conv_done |
| mode_sel | input | 2 | Format select (00 left, 01 right, 10 signed left, 11 truncated) |
| rd_stb | input | 1 | Register read strobe |
| rd_sel | input | 1 | Register select: 1 = upper, 0 = lower |
| rd_data | output | 8 | Formatted contents of the selected register |

## Verification
The assertions check three things on every cycle: that a blocked conversion leaves the held value untouched, that the lock clears only after a lower-register read, and that an upper-register read arms the release. They also check that a format change alone never moves the lock, and that unused register bits read zero. Only the bench scenarios can show that the held value appears correctly in each format. The same holds for a full wrong-order read sequence keeping the lock closed, for a conversion colliding with the releasing read being lost, and for the lock state surviving a stretch in truncated mode.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  typedef enum logic [1:0] {
    FMT_LEFT        = 2'b00,
    FMT_RIGHT       = 2'b01,
    FMT_LEFT_SIGNED = 2'b10,
    FMT_TRUNC8      = 2'b11
  } fmt_mode_e;

  typedef enum logic [1:0] {
    LK_OPEN  = 2'b00,
    LK_HELD  = 2'b01,
    LK_ARMED = 2'b10
  } lock_st_e;
endpackage

// File: rtl/adc_lock_ctrl.sv
module adc_lock_ctrl
  import adc_fmt_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  input  logic             trunc_mode,
  input  logic             rd_hi_stb,
  input  logic             rd_lo_stb,
  output logic [RES_W-1:0] held_res,
  output logic             held_vld,
  output lock_st_e         lock_st
);
  logic     store_evt;
  logic     arm_evt;
  logic     release_evt;
  lock_st_e lock_nxt;

  assign store_evt   = conv_done && (trunc_mode || lock_st == LK_OPEN);
  assign arm_evt     = !trunc_mode && lock_st == LK_HELD  && rd_hi_stb;
  assign release_evt = !trunc_mode && lock_st == LK_ARMED && rd_lo_stb;

  always_comb begin
    lock_nxt = lock_st;
    if (!trunc_mode) begin
      unique case (lock_st)
        LK_OPEN:  if (conv_done)   lock_nxt = LK_HELD;
        LK_HELD:  if (arm_evt)     lock_nxt = LK_ARMED;
        LK_ARMED: if (release_evt) lock_nxt = LK_OPEN;
        default:                   lock_nxt = LK_OPEN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_st  <= LK_OPEN;
      held_res <= '0;
      held_vld <= 1'b0;
    end else begin
      lock_st <= lock_nxt;
      if (store_evt) begin
        held_res <= conv_data;
        held_vld <= 1'b1;
      end
    end
  end

  // R6
  drop_keeps_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !trunc_mode && lock_st != LK_OPEN) |=> $stable(held_res));

  // R6
  store_engages_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !trunc_mode && lock_st == LK_OPEN) |=>
      (lock_st == LK_HELD && held_res == $past(conv_data)));

  // R7
  hi_read_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trunc_mode && lock_st == LK_HELD && rd_hi_stb) |=> lock_st == LK_ARMED);

  // R8
  release_after_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_st == LK_OPEN && $past(lock_st) != LK_OPEN) |->
      ($past(rd_lo_stb) && $past(lock_st) == LK_ARMED));

  // R9
  trunc_lock_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trunc_mode |=> (lock_st == $past(lock_st)));
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt
  import adc_fmt_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int REG_W = 8
) (
  input  logic [RES_W-1:0] res,
  input  logic             vld,
  input  fmt_mode_e        mode,
  input  logic             sel_hi,
  output logic [REG_W-1:0] rd_data
);
  localparam int SPILL = RES_W - REG_W;
  localparam int PAD   = REG_W - SPILL;

  function automatic logic [REG_W-1:0] fmt_hi(input logic [RES_W-1:0] r, input fmt_mode_e m);
    unique case (m)
      FMT_LEFT:        return r[RES_W-1 -: REG_W];
      FMT_LEFT_SIGNED: return {~r[RES_W-1], r[RES_W-2 -: REG_W-1]};
      FMT_RIGHT:       return {{PAD{1'b0}}, r[RES_W-1 -: SPILL]};
      default:         return '0;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] fmt_lo(input logic [RES_W-1:0] r, input fmt_mode_e m);
    unique case (m)
      FMT_LEFT, FMT_LEFT_SIGNED: return {r[SPILL-1:0], {PAD{1'b0}}};
      FMT_RIGHT:                 return r[REG_W-1:0];
      default:                   return r[RES_W-1 -: REG_W];
    endcase
  endfunction

  always_comb begin
    if (!vld)        rd_data = '0;
    else if (sel_hi) rd_data = fmt_hi(res, mode);
    else             rd_data = fmt_lo(res, mode);
  end

  // R3
  always_comb begin
    if (mode == FMT_RIGHT && sel_hi)
      right_pad_zero_chk: assert (rd_data[REG_W-1:SPILL] == '0);
  end

  // R5
  always_comb begin
    if (mode == FMT_TRUNC8 && sel_hi)
      trunc_hi_zero_chk: assert (rd_data == '0);
  end
endmodule

// File: rtl/adc_result_port.sv
module adc_result_port
  import adc_fmt_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  input  logic [1:0]       mode_sel,
  input  logic             rd_stb,
  input  logic             rd_sel,
  output logic [REG_W-1:0] rd_data
);
  fmt_mode_e        mode;
  logic             trunc_mode;
  logic             rd_hi_stb;
  logic             rd_lo_stb;
  logic [RES_W-1:0] held_res;
  logic             held_vld;
  lock_st_e         lock_st;

  assign mode       = fmt_mode_e'(mode_sel);
  assign trunc_mode = (mode == FMT_TRUNC8);
  assign rd_hi_stb  = rd_stb && rd_sel;
  assign rd_lo_stb  = rd_stb && !rd_sel;

  adc_lock_ctrl #(.RES_W(RES_W)) lock_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_done  (conv_done),
    .conv_data  (conv_data),
    .trunc_mode (trunc_mode),
    .rd_hi_stb  (rd_hi_stb),
    .rd_lo_stb  (rd_lo_stb),
    .held_res   (held_res),
    .held_vld   (held_vld),
    .lock_st    (lock_st)
  );

  adc_result_fmt #(.RES_W(RES_W), .REG_W(REG_W)) fmt_i (
    .res     (held_res),
    .vld     (held_vld),
    .mode    (mode),
    .sel_hi  (rd_sel),
    .rd_data (rd_data)
  );

  // R10
  mode_change_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != $past(mode_sel) && !$past(conv_done) && !$past(rd_stb))
      |-> lock_st == $past(lock_st));

  // R1
  reset_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !held_vld |-> (rd_data == '0 && lock_st == LK_OPEN));
endmodule

// File: tb/adc_result_port_tb_top.sv
module adc_result_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_done = 1'b0;
  logic [9:0] conv_data = '0;
  logic [1:0] mode_sel = 2'b00;
  logic       rd_stb = 1'b0;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  int m_phase = 0;   // 0 open, 1 held, 2 armed
  int m_val = 0;
  bit m_vld = 0;

  always #2.5 clk = ~clk;

  adc_result_port dut_i (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
    .mode_sel(mode_sel), .rd_stb(rd_stb), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  function automatic int expect_val(int v, bit vld, int mode, bit hi);
    int top;
    if (!vld) return 0;
    case (mode)
      0: top = v / 4;
      2: top = (v ^ 512) / 4;
      default: top = 0;
    endcase
    if (hi) begin
      if (mode == 1) return v / 256;
      return top;
    end
    case (mode)
      1: return v % 256;
      3: return v / 4;
      default: return (v % 4) * 64;
    endcase
  endfunction

  task automatic step(input string tag, input bit cd, input int data,
                      input int mode, input bit rs, input bit sel);
    int exp;
    @(negedge clk);
    conv_done = cd; conv_data = data[9:0]; mode_sel = mode[1:0];
    rd_stb = rs; rd_sel = sel;
    #1;
    exp = expect_val(m_val, m_vld, mode, sel);
    n_run++;
    if (int'(rd_data) != exp) begin
      n_fail++;
      $display("FAIL %s: rd_data=0x%02h expected 0x%02h (mode %0d sel %0d)",
               tag, rd_data, exp[7:0], mode, sel);
    end
    if (mode == 3) begin
      if (cd) begin m_val = data; m_vld = 1; end
    end else begin
      case (m_phase)
        0: if (cd) begin m_val = data; m_vld = 1; m_phase = 1; end
        1: if (rs && sel) m_phase = 2;
        default: if (rs && !sel) m_phase = 0;
      endcase
    end
    @(posedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #20000;
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    step("R1", 0, 0, 0, 0, 1);
    step("R1", 0, 0, 2, 0, 1);
    step("R1", 0, 0, 0, 0, 0);
    // R2 capture and left-aligned layout
    step("R2", 1, 'h2D7, 0, 0, 1);
    step("R2", 0, 0, 0, 0, 1);
    step("R2", 0, 0, 0, 0, 0);
    // R6 dropped while held
    step("R6", 1, 'h155, 0, 0, 1);
    step("R6", 0, 0, 0, 0, 1);
    step("R6", 0, 0, 0, 0, 0);
    // R8 low read first does not release
    step("R8", 0, 0, 0, 1, 0);
    step("R8", 1, 'h0AA, 0, 0, 1);
    step("R8", 0, 0, 0, 0, 1);
    // R7 high then low releases
    step("R7", 0, 0, 0, 1, 1);
    step("R7", 0, 0, 0, 1, 0);
    step("R7", 1, 'h3FF, 0, 0, 1);
    step("R7", 0, 0, 0, 0, 1);
    // R3 / R10 reformat of held value, lock unchanged
    step("R3", 0, 0, 1, 0, 1);
    step("R3", 0, 0, 1, 0, 0);
    step("R10", 1, 'h001, 1, 0, 0);
    step("R10", 0, 0, 0, 0, 1);
    // R11 collision with releasing read
    step("R11", 0, 0, 0, 1, 1);
    step("R11", 1, 'h123, 0, 1, 0);
    step("R11", 0, 0, 0, 0, 1);
    step("R11", 1, 'h123, 0, 0, 1);
    step("R11", 0, 0, 0, 0, 0);
    // R4 signed-left layout
    step("R4", 0, 0, 2, 0, 1);
    step("R4", 0, 0, 2, 0, 0);
    step("R4", 0, 0, 2, 1, 1);
    step("R4", 0, 0, 2, 1, 0);
    step("R4", 1, 'h3FF, 2, 0, 1);
    step("R4", 0, 0, 2, 0, 0);
    // R5 / R9 truncated mode bypasses lock
    step("R5", 1, 'h2D7, 3, 0, 0);
    step("R5", 0, 0, 3, 0, 0);
    step("R5", 0, 0, 3, 0, 1);
    step("R9", 1, 'h0FF, 3, 1, 1);
    step("R9", 0, 0, 3, 1, 0);
    step("R9", 0, 0, 3, 0, 0);
    step("R9", 1, 'h100, 0, 0, 1);
    step("R9", 0, 0, 0, 0, 1);
    step("R9", 0, 0, 0, 0, 0);
    // release and confirm normal capture resumes
    step("R7", 0, 0, 1, 1, 1);
    step("R7", 0, 0, 1, 1, 0);
    step("R7", 1, 'h2C1, 1, 0, 1);
    step("R3", 0, 0, 1, 0, 0);
    step("R2", 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule